// File: doc/BRIEF.md
# Dual-Protocol Host Bus Register Interface

This block is an 8-bit host processor slave port that lets a microprocessor read and write a small bank of 8-bit configuration and alarm registers. Two static strap inputs choose the bus style. One style uses chip select, a data strobe and a read/write level. The other uses chip select with separate read and write strobes. Either style can use separate address and data buses, or a shared bus that first carries the address, captured while the address-latch strobe is high, and then the data.

An internal wait-state generator drives a single handshake output. For the strobe-plus-direction style it is an acknowledge that goes low when the access is complete. For the separate-strobe style it is a ready line that goes low while an access is still in progress. A write to the soft-reset register restores every writable register to its default and then holds the port off for a fixed time counted in clock cycles. Sticky alarm status bits, each with its own mask bit, drive an active-low interrupt.

Host strobes are taken to be synchronous to `clk_i`. The data bus is modelled as a separate input, output and output-enable.

Top module: `hbi_host_port`

## Requirements
- R1: `mot_sel_i`=1 selects control by `cs_ni`, `ds_ni` and `rw_i` (1 = read). `mot_sel_i`=0 selects control by `cs_ni`, `rd_ni` and `wr_ni`. A value written in either style reads back in either style.
- R2: When `mux_sel_i`=1, the register address is `data_i[4:0]`, captured on each clock edge at which `ale_i`=1, and `addr_i` is ignored. When `mux_sel_i`=0, the address is `addr_i`.
- R3: An access is complete exactly WAIT_CYC+1 rising clock edges after the first edge that samples its strobe, provided no reset hold-off is running. `hs_o` is 1 whenever `cs_ni` is 1.
- R4: With `mot_sel_i`=1, `hs_o` goes low only when the access is complete, and `data_o` stays stable while it is low. With `mot_sel_i`=0, `hs_o` is low from the strobe until completion and then returns high.
- R5: `data_oe_o` is 1 only during a read strobe: `cs_ni`=0 and `ds_ni`=0 with `rw_i`=1, or `cs_ni`=0 with `rd_ni`=0.
- R6: Register map:
  - 0x00–0x09, 0x0B–0x0F and 0x11–0x14 are read/write.
  - 0x11 is the alarm mask and resets to 0xFF; every other writable register resets to 0x00.
  - 0x10 is the alarm status and is read-only.
  - 0x15 reads the live `alarm_i` and is read-only.
  - 0x0A and 0x16–0x1F read 0x00.
  - Writes to read-only or unimplemented addresses have no effect.
- R7: A status bit is set on any edge where the matching `alarm_i` bit is 1. The bit stays set until a completed read of 0x10, which clears the bits whose alarm input is 0. `irq_no` is 0 exactly when some status bit is 1 while its mask bit is 0.
- R8: A completed write to 0x0A returns every writable register to its default. With `mot_sel_i`=0 and `mux_sel_i`=0, such a write keeps `hs_o` at 1 for the whole access.
- R9: After a write to 0x0A, no new access completes until RST_CYC = CLK_MHZ*RST_US edges have passed since that write was first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mot_sel_i | input | 1 | Strap: 1 = strobe and direction control, 0 = separate read and write strobes |
| mux_sel_i | input | 1 | Strap: 1 = shared address/data bus |
| cs_ni | input | 1 | Chip select, active low |
| ds_ni | input | 1 | Data strobe, active low (mot_sel_i=1) |
| rw_i | input | 1 | 1 = read, 0 = write (mot_sel_i=1) |
| rd_ni | input | 1 | Read strobe, active low (mot_sel_i=0) |
| wr_ni | input | 1 | Write strobe, active low (mot_sel_i=0) |
| ale_i | input | 1 | Address latch strobe (mux_sel_i=1) |
| addr_i | input | 5 | Register address (mux_sel_i=0) |
| data_i | input | 8 | Bus data in; also the address when the bus is shared |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Bus drive enable |
| hs_o | output | 1 | Acknowledge or ready handshake |
| alarm_i | input | 8 | Alarm event inputs |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The hardest case to reach is the reset hold-off: a new access is already waiting on the bus while the timer counts out. The bench gets there by starting a read immediately after a soft-reset write and measuring how long it takes to complete, which also shows that the defaults were restored. The clear-on-read race, where an alarm input is still high while the status register is being read, is driven by holding `alarm_i` steady across the read and then checking that the interrupt comes back at once.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_RESET    = 5'h0A;
  localparam logic [ADDR_W-1:0] ADDR_STAT     = 5'h10;
  localparam logic [ADDR_W-1:0] ADDR_MASK     = 5'h11;
  localparam logic [ADDR_W-1:0] ADDR_LAST_CFG = 5'h14;
  localparam logic [ADDR_W-1:0] ADDR_LIVE     = 5'h15;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} cyc_state_e;

  function automatic logic is_cfg(input logic [ADDR_W-1:0] a);
    return (a <= ADDR_LAST_CFG) && (a != ADDR_RESET) && (a != ADDR_STAT);
  endfunction

  function automatic logic [DATA_W-1:0] cfg_default(input logic [ADDR_W-1:0] a);
    return (a == ADDR_MASK) ? 8'hFF : 8'h00;
  endfunction
endpackage

// File: rtl/hbi_bus_decode.sv
module hbi_bus_decode
  import hbi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mot_i,
  input  logic              mux_i,
  input  logic              cs_ni,
  input  logic              ds_ni,
  input  logic              rw_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              ale_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              strobe_o,
  output logic              read_o,
  output logic              write_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] lat_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lat_addr_q <= '0;
    else if (ale_i) lat_addr_q <= bus_addr_i;
  end

  always_comb begin
    if (mot_i) begin
      read_o  = !cs_ni && !ds_ni && rw_i;
      write_o = !cs_ni && !ds_ni && !rw_i;
    end else begin
      read_o  = !cs_ni && !rd_ni;
      write_o = !cs_ni && !wr_ni && rd_ni;  // read wins if both strobes low
    end
    strobe_o = read_o || write_o;
    addr_o   = mux_i ? lat_addr_q : addr_i;
  end
endmodule

// File: rtl/hbi_cycle_ctrl.sv
module hbi_cycle_ctrl
  import hbi_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 2,
  parameter int unsigned RST_CYC  = 375
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mot_i,
  input  logic              mux_i,
  input  logic              cs_ni,
  input  logic              strobe_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              detect_o,
  output logic              commit_o,
  output logic              soft_rst_o,
  output logic              busy_o,
  output logic              hs_o
);
  localparam int unsigned WC_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam int unsigned RC_W = $clog2(RST_CYC + 1);
  localparam logic [WC_W-1:0] WAIT_LOAD = WC_W'(WAIT_CYC - 1);
  localparam logic [RC_W-1:0] RST_LOAD  = RC_W'(RST_CYC - WAIT_CYC);

  cyc_state_e      state_q;
  logic [WC_W-1:0] wcnt_q;
  logic [RC_W-1:0] rcnt_q;
  logic            acc_rst_q;

  assign busy_o     = (rcnt_q != '0);
  assign detect_o   = (state_q == ST_IDLE) && strobe_i && !busy_o;
  assign commit_o   = (state_q == ST_WAIT) && (wcnt_q == '0);
  assign soft_rst_o = commit_o && acc_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      wcnt_q    <= '0;
      acc_rst_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (detect_o) begin
          state_q   <= ST_WAIT;
          wcnt_q    <= WAIT_LOAD;
          acc_rst_q <= write_i && (addr_i == ADDR_RESET);
        end
        ST_WAIT: if (commit_o) state_q <= ST_DONE;
                 else          wcnt_q  <= wcnt_q - 1'b1;
        ST_DONE: if (!strobe_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // hold-off timer runs from the edge that sampled the reset write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rcnt_q <= '0;
    else if (soft_rst_o) rcnt_q <= RST_LOAD;
    else if (busy_o)     rcnt_q <= rcnt_q - 1'b1;
  end

  always_comb begin
    if (cs_ni)
      hs_o = 1'b1;
    else if (mot_i)
      hs_o = (state_q != ST_DONE);
    else if (!mux_i && write_i && (addr_i == ADDR_RESET))
      hs_o = 1'b1;
    else
      hs_o = !((state_q == ST_WAIT) || (strobe_i && (state_q == ST_IDLE)));
  end
endmodule

// File: rtl/hbi_regfile.sv
module hbi_regfile
  import hbi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              detect_i,
  input  logic              commit_i,
  input  logic              soft_rst_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] alarm_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_no
);
  localparam int unsigned NUM_CFG = int'(ADDR_LAST_CFG) + 1;

  logic [ADDR_W-1:0] acc_addr_q;
  logic              acc_wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] cfg_w [NUM_CFG];
  logic              wr_hit;
  logic              rd_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_addr_q <= '0;
      acc_wr_q   <= 1'b0;
      wdata_q    <= '0;
    end else if (detect_i) begin
      acc_addr_q <= addr_i;
      acc_wr_q   <= write_i;
      wdata_q    <= wdata_i;
    end
  end

  assign wr_hit = commit_i && acc_wr_q;
  assign rd_hit = commit_i && !acc_wr_q;

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    localparam logic [ADDR_W-1:0] A = ADDR_W'(i);
    if (is_cfg(A)) begin : g_rw
      logic [DATA_W-1:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       r_q <= cfg_default(A);
        else if (soft_rst_i)               r_q <= cfg_default(A);
        else if (wr_hit && acc_addr_q == A) r_q <= wdata_q;
      end
      assign cfg_w[i] = r_q;
    end else begin : g_none
      assign cfg_w[i] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              status_q <= '0;
    else if (rd_hit && acc_addr_q == ADDR_STAT) status_q <= alarm_i;
    else                                      status_q <= status_q | alarm_i;
  end

  always_comb begin
    if (acc_addr_q == ADDR_STAT)          rd_val = status_q;
    else if (acc_addr_q == ADDR_LIVE)     rd_val = alarm_i;
    else if (acc_addr_q <= ADDR_LAST_CFG) rd_val = cfg_w[acc_addr_q];
    else                                  rd_val = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_hit) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
  assign irq_no  = ~|(status_q & ~cfg_w[ADDR_MASK]);
endmodule

// File: rtl/hbi_host_port.sv
module hbi_host_port
  import hbi_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 2,
  parameter int unsigned CLK_MHZ  = 125,
  parameter int unsigned RST_US   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mot_sel_i,
  input  logic              mux_sel_i,
  input  logic              cs_ni,
  input  logic              ds_ni,
  input  logic              rw_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              ale_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              hs_o,
  input  logic [DATA_W-1:0] alarm_i,
  output logic              irq_no
);
  localparam int unsigned RST_CYC = CLK_MHZ * RST_US;

  logic              dec_strobe, dec_read, dec_write;
  logic [ADDR_W-1:0] dec_addr;
  logic              acc_detect, acc_commit, soft_rst, rst_busy;

  hbi_bus_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mot_i      (mot_sel_i),
    .mux_i      (mux_sel_i),
    .cs_ni      (cs_ni),
    .ds_ni      (ds_ni),
    .rw_i       (rw_i),
    .rd_ni      (rd_ni),
    .wr_ni      (wr_ni),
    .ale_i      (ale_i),
    .addr_i     (addr_i),
    .bus_addr_i (data_i[ADDR_W-1:0]),
    .strobe_o   (dec_strobe),
    .read_o     (dec_read),
    .write_o    (dec_write),
    .addr_o     (dec_addr)
  );

  hbi_cycle_ctrl #(.WAIT_CYC(WAIT_CYC), .RST_CYC(RST_CYC)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mot_i      (mot_sel_i),
    .mux_i      (mux_sel_i),
    .cs_ni      (cs_ni),
    .strobe_i   (dec_strobe),
    .write_i    (dec_write),
    .addr_i     (dec_addr),
    .detect_o   (acc_detect),
    .commit_o   (acc_commit),
    .soft_rst_o (soft_rst),
    .busy_o     (rst_busy),
    .hs_o       (hs_o)
  );

  hbi_regfile u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .detect_i   (acc_detect),
    .commit_i   (acc_commit),
    .soft_rst_i (soft_rst),
    .write_i    (dec_write),
    .addr_i     (dec_addr),
    .wdata_i    (data_i),
    .alarm_i    (alarm_i),
    .rdata_o    (data_o),
    .irq_no     (irq_no)
  );

  assign data_oe_o = dec_read;
endmodule

// File: rtl/hbi_host_port_chk.sv
module hbi_host_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mot_sel_i,
  input logic       cs_ni,
  input logic       hs_o,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       busy_i
);
  a_r5_oe_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !cs_ni);

  a_r4_ack_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mot_sel_i && !hs_o && !cs_ni) |=> (hs_o || $stable(data_o)));

  a_r3_ack_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mot_sel_i && $fell(hs_o)) |-> !cs_ni);

  a_r4_rdy_low_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mot_sel_i && !hs_o) |-> !cs_ni);

  a_r9_no_ack_in_holdoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mot_sel_i && busy_i && $past(busy_i)) |-> !$fell(hs_o));
endmodule

bind hbi_host_port hbi_host_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mot_sel_i (mot_sel_i),
  .cs_ni     (cs_ni),
  .hs_o      (hs_o),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .busy_i    (rst_busy)
);

// File: tb/sim_hbi_host_port.sv
`timescale 1ns/1ps
module sim_hbi_host_port;
  localparam int WAIT_CYC = 2;
  localparam int CLK_MHZ  = 125;
  localparam int RST_US   = 3;
  localparam int RST_CYC  = CLK_MHZ * RST_US;
  localparam int NVEC     = 14;

  // {mot, mux, wr, addr[4:0], wdata[7:0], exp[7:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b1, 5'h03, 8'hA5, 8'h00},
    {1'b1, 1'b0, 1'b0, 5'h03, 8'h00, 8'hA5},
    {1'b0, 1'b0, 1'b1, 5'h14, 8'h3C, 8'h00},
    {1'b0, 1'b0, 1'b0, 5'h14, 8'h00, 8'h3C},
    {1'b1, 1'b1, 1'b1, 5'h0F, 8'h77, 8'h00},
    {1'b0, 1'b1, 1'b0, 5'h0F, 8'h00, 8'h77},
    {1'b0, 1'b1, 1'b1, 5'h10, 8'hFF, 8'h00},
    {1'b1, 1'b0, 1'b0, 5'h10, 8'h00, 8'h00},
    {1'b0, 1'b0, 1'b0, 5'h11, 8'h00, 8'hFF},
    {1'b1, 1'b1, 1'b0, 5'h1C, 8'h00, 8'h00},
    {1'b0, 1'b0, 1'b1, 5'h1C, 8'h99, 8'h00},
    {1'b0, 1'b0, 1'b0, 5'h1C, 8'h00, 8'h00},
    {1'b1, 1'b0, 1'b0, 5'h0A, 8'h00, 8'h00},
    {1'b0, 1'b1, 1'b0, 5'h00, 8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mot_sel = 1'b1, mux_sel = 1'b0;
  logic       cs_n = 1'b1, ds_n = 1'b1, rw = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ale = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] data_in = '0, alarm = '0;
  logic [7:0] data_out;
  logic       data_oe, hs, irq_n;

  int n_run = 0, n_fail = 0;
  int last_lat;
  logic [7:0] last_rd;
  logic last_oe, last_low;

  always #4 clk = ~clk;

  hbi_host_port #(.WAIT_CYC(WAIT_CYC), .CLK_MHZ(CLK_MHZ), .RST_US(RST_US)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mot_sel_i(mot_sel), .mux_sel_i(mux_sel),
    .cs_ni(cs_n), .ds_ni(ds_n), .rw_i(rw), .rd_ni(rd_n), .wr_ni(wr_n), .ale_i(ale),
    .addr_i(addr), .data_i(data_in), .data_o(data_out), .data_oe_o(data_oe),
    .hs_o(hs), .alarm_i(alarm), .irq_no(irq_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic mot, input logic mux, input logic wr,
                        input logic [4:0] a, input logic [7:0] wd);
    logic done;
    @(negedge clk);
    mot_sel = mot; mux_sel = mux;
    if (mux) begin
      data_in = {3'b111, a};  // upper bits must not matter
      addr = 5'h1F;           // ignored in shared-bus mode
      ale = 1'b1;
      @(negedge clk);
      ale = 1'b0;
    end else addr = a;
    data_in = wr ? wd : 8'h00;
    cs_n = 1'b0;
    if (mot) begin rw = !wr; ds_n = 1'b0; end
    else if (wr) wr_n = 1'b0;
    else rd_n = 1'b0;
    last_lat = 0; done = 1'b0; last_low = 1'b0;
    while (!done && last_lat < 2000) begin
      @(negedge clk);
      last_lat++;
      if (!mot && !hs) last_low = 1'b1;
      done = mot ? !hs : hs;
    end
    last_rd = data_out;
    last_oe = data_oe;
    cs_n = 1'b1; ds_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; rw = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1_400_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic all_high;
    repeat (3) @(negedge clk);
    // reset state
    check("R3 hs idle in reset", hs, 1);
    check("R7 irq idle in reset", irq_n, 1);
    check("R5 oe idle in reset", data_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R6: table walk over all four bus modes
    for (int i = 0; i < NVEC; i++) begin
      logic [23:0] v;
      v = VEC[i];
      access(v[23], v[22], v[21], v[20:16], v[15:8]);
      if (!v[21]) check($sformatf("R1/R2/R6 vec %0d read", i), last_rd, v[7:0]);
      check($sformatf("R3 vec %0d latency", i), last_lat, WAIT_CYC + 1);
      check($sformatf("R5 vec %0d oe at done", i), last_oe, !v[21]);
      if (!v[23]) check($sformatf("R4 vec %0d rdy low in cycle", i), last_low, 1);
      check($sformatf("R3 vec %0d hs with cs high", i), hs, 1);
      check($sformatf("R5 vec %0d oe after", i), data_oe, 0);
    end

    // R7: alarm status, mask, clear on read
    access(1, 0, 1, 5'h11, 8'h00);
    check("R7 no irq without status", irq_n, 1);
    alarm = 8'h05;
    @(negedge clk);
    check("R7 irq on alarm", irq_n, 0);
    alarm = 8'h00;
    access(1, 0, 0, 5'h10, 8'h00);
    check("R7 sticky status read", last_rd, 8'h05);
    check("R7 irq after clear", irq_n, 1);
    access(0, 0, 0, 5'h10, 8'h00);
    check("R7 status cleared", last_rd, 8'h00);
    alarm = 8'h30;
    access(0, 1, 0, 5'h15, 8'h00);
    check("R6 live alarm read", last_rd, 8'h30);
    access(1, 0, 0, 5'h10, 8'h00);
    check("R7 status with held alarm", last_rd, 8'h30);
    check("R7 held alarm re-sets", irq_n, 0);
    alarm = 8'h00;
    access(1, 0, 0, 5'h10, 8'h00);
    check("R7 status after held", last_rd, 8'h30);
    access(1, 0, 1, 5'h11, 8'h04);
    alarm = 8'h04;
    @(negedge clk);
    alarm = 8'h00;
    @(negedge clk);
    check("R7 masked alarm no irq", irq_n, 1);
    access(1, 0, 0, 5'h10, 8'h00);
    check("R7 masked bit still in status", last_rd, 8'h04);

    // R8 R9: reset write then immediate read waits out the hold-off
    access(1, 0, 1, 5'h0A, 8'h01);
    check("R3 reset write latency", last_lat, WAIT_CYC + 1);
    access(1, 0, 0, 5'h03, 8'h00);
    n_run++;
    if (last_lat < RST_CYC - 8 || last_lat > RST_CYC + 4) begin
      n_fail++;
      $display("FAIL R9 hold-off act=%0d exp=%0d", last_lat, RST_CYC);
    end
    check("R8 cfg restored", last_rd, 8'h00);
    access(0, 0, 0, 5'h11, 8'h00);
    check("R8 mask restored", last_rd, 8'hFF);

    // R8: separate-strobe non-shared reset write keeps ready high
    access(0, 0, 1, 5'h05, 8'h66);
    @(negedge clk);
    mot_sel = 1'b0; mux_sel = 1'b0; addr = 5'h0A; data_in = 8'h01;
    cs_n = 1'b0; wr_n = 1'b0;
    all_high = 1'b1;
    for (int k = 0; k < WAIT_CYC + 4; k++) begin
      @(negedge clk);
      if (!hs) all_high = 1'b0;
    end
    cs_n = 1'b1; wr_n = 1'b1;
    check("R8 rdy stays high on reset write", all_high, 1);
    repeat (RST_CYC + 10) @(negedge clk);
    access(0, 0, 0, 5'h05, 8'h00);
    check("R8 reset via ready-style write", last_rd, 8'h00);
    check("R9 access after hold-off", last_lat, WAIT_CYC + 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule